// File: doc/BRIEF.md
# Dual-Issue Slot Reservation Checker

This block sits in the issue stage of a dual-issue, in-order front end. Each cycle it receives two candidate instructions. Slot 0 holds the older one and slot 1 the younger. Each candidate comes with a valid bit and a 4-bit class code. The block answers with one grant bit per slot.

Every class is tied to a fixed issue bus, with one exception: loads may take either bus. Most classes also occupy one of four execution resources: the memory unit, the branch unit, the integer unit or the floating-point unit. The checker refuses a pairing that would use the same bus or the same unit twice. It never lets the younger instruction issue without the older one.

Barriers and branches keep their unit reserved after their issue cycle. Each of these two units has a small hold controller. Its state `HOLD_IDLE` moves to `HOLD_ACTIVE` on the transition *claim*, which is a granted barrier or branch. It stays in `HOLD_ACTIVE` while a down-counter runs. It returns to `HOLD_IDLE` on the transition *expire*, taken when the counter reaches zero. All state clears on synchronous reset.

Top module: `issue_slot_checker`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) both units are free, so a valid memory or branch instruction in slot 0 is granted in the first cycle after reset.
- R2: Class codes are 0 multi (both buses, no unit), 1 load (either bus, memory), 2 integer store and 3 store-conditional (bus 1, memory), 4 FP store (bus 0, memory), 5 barrier (bus 1, memory), 6 branch, 7 jump and 8 privileged call (bus 1, branch), 9 FP branch (bus 0, branch), 10 add/logic, 11 shift/move and 12 compare (bus 0, integer), 13 FP arithmetic (bus 1, FP), 14 and 15 trap/misc (bus 1, no unit). A valid slot-0 instruction is granted unless its unit is held.
- R3: `s1_grant` is never high in a cycle where `s0_grant` is low.
- R4: When either candidate is class 0 (multi), slot 1 is not granted.
- R5: When both candidates need the same fixed bus, only slot 0 is granted.
- R6: A load takes whichever bus the other candidate leaves free. A load therefore pairs with any non-multi instruction that does not use the memory unit.
- R7: When both candidates use the same execution unit, only slot 0 is granted.
- R8: A granted barrier holds the memory unit for the 3 cycles after its issue cycle. Memory-class instructions are refused in those cycles and accepted again in the 4th cycle.
- R9: A granted branch-class instruction (codes 6 to 9) holds the branch unit for the 1 cycle after its issue cycle.
- R10: A candidate whose valid bit is low is never granted and reserves nothing. A slot 1 that is valid behind an invalid slot 0 is not granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_valid | input | 1 | Slot 0 (older) candidate present |
| s0_class | input | 4 | Slot 0 class code |
| s1_valid | input | 1 | Slot 1 (younger) candidate present |
| s1_class | input | 4 | Slot 1 class code |
| s0_grant | output | 1 | Slot 0 may issue this cycle |
| s1_grant | output | 1 | Slot 1 may issue this cycle |

## Verification
Two functions can meet in one cycle: the expiry of a unit hold and the pairing check between the two slots. The bench provokes this by placing a memory or branch instruction in either slot exactly on the cycle a barrier or branch hold runs out, while the other slot competes for the same bus or unit. The expected grants come from a reference model in the bench. That model keeps its own hold counters and decides the grants from the class table, cycle by cycle.

// File: rtl/issue_slot_pkg.sv
package issue_slot_pkg;

    localparam int CLS_W = 4;
    localparam int NSLOT = 2;

    typedef enum logic [CLS_W-1:0] {
        C_MULTI  = 4'd0,
        C_LOAD   = 4'd1,
        C_ISTORE = 4'd2,
        C_STCOND = 4'd3,
        C_FSTORE = 4'd4,
        C_BARR   = 4'd5,
        C_BRANCH = 4'd6,
        C_JUMP   = 4'd7,
        C_PCALL  = 4'd8,
        C_FBR    = 4'd9,
        C_IADD   = 4'd10,
        C_ISHIFT = 4'd11,
        C_ICMP   = 4'd12,
        C_FPOP   = 4'd13,
        C_MISC   = 4'd14,
        C_MISC2  = 4'd15
    } iclass_e;

    typedef struct packed {
        logic bus0;
        logic bus1;
        logic flex;
        logic mem;
        logic br;
        logic alu;
        logic fpu;
        logic barrier;
    } slot_need_t;

    typedef enum logic {
        HOLD_IDLE   = 1'b0,
        HOLD_ACTIVE = 1'b1
    } hold_state_e;

endpackage

// File: rtl/slot_decode.sv
module slot_decode
    import issue_slot_pkg::*;
(
    input  logic             valid,
    input  logic [CLS_W-1:0] cls,
    output slot_need_t       need
);

    slot_need_t raw;

    always_comb begin
        raw = '0;
        case (cls)
            C_MULTI:                 begin raw.bus0 = 1'b1; raw.bus1 = 1'b1; end
            C_LOAD:                  begin raw.flex = 1'b1; raw.mem  = 1'b1; end
            C_ISTORE, C_STCOND:      begin raw.bus1 = 1'b1; raw.mem  = 1'b1; end
            C_FSTORE:                begin raw.bus0 = 1'b1; raw.mem  = 1'b1; end
            C_BARR:                  begin raw.bus1 = 1'b1; raw.mem  = 1'b1; raw.barrier = 1'b1; end
            C_BRANCH, C_JUMP, C_PCALL: begin raw.bus1 = 1'b1; raw.br = 1'b1; end
            C_FBR:                   begin raw.bus0 = 1'b1; raw.br   = 1'b1; end
            C_IADD, C_ISHIFT, C_ICMP: begin raw.bus0 = 1'b1; raw.alu = 1'b1; end
            C_FPOP:                  begin raw.bus1 = 1'b1; raw.fpu  = 1'b1; end
            default:                 begin raw.bus1 = 1'b1; end
        endcase
    end

    assign need = valid ? raw : '0;

endmodule

// File: rtl/unit_hold.sv
module unit_hold
    import issue_slot_pkg::*;
#(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic claim,
    output logic busy
);

    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD - 1);

    hold_state_e   state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            HOLD_IDLE: begin
                if (claim) begin
                    state_nx = HOLD_ACTIVE;
                    cnt_nx   = LOAD_VAL;
                end
            end
            HOLD_ACTIVE: begin
                if (cnt == '0) state_nx = HOLD_IDLE;
                else           cnt_nx   = cnt - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HOLD_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        busy = (state == HOLD_ACTIVE);
    end

    // R8 / R9: a new reservation only starts on a free unit
    p_claim_idle_r8: assert property (@(posedge clk) disable iff (rst)
        claim |-> !busy);

    // R8 / R9: the unit becomes held only after a claim
    p_hold_after_claim_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(claim));

endmodule

// File: rtl/pair_arbiter.sv
module pair_arbiter
    import issue_slot_pkg::*;
(
    input  slot_need_t n0,
    input  slot_need_t n1,
    input  logic       v0,
    input  logic       v1,
    input  logic       mem_busy,
    input  logic       br_busy,
    output logic       g0,
    output logic       g1,
    output logic       mem_claim,
    output logic       br_claim
);

    logic multi0, multi1, bus_clash, unit_clash, blocked0, blocked1;

    always_comb begin
        multi0     = n0.bus0 & n0.bus1;
        multi1     = n1.bus0 & n1.bus1;
        bus_clash  = multi0 | multi1 |
                     (~n0.flex & ~n1.flex &
                      ((n0.bus0 & n1.bus0) | (n0.bus1 & n1.bus1)));
        unit_clash = (n0.mem & n1.mem) | (n0.br & n1.br) |
                     (n0.alu & n1.alu) | (n0.fpu & n1.fpu);
        blocked0   = (n0.mem & mem_busy) | (n0.br & br_busy);
        blocked1   = (n1.mem & mem_busy) | (n1.br & br_busy);
        g0         = v0 & ~blocked0;
        g1         = g0 & v1 & ~blocked1 & ~bus_clash & ~unit_clash;
        mem_claim  = (g0 & n0.barrier) | (g1 & n1.barrier);
        br_claim   = (g0 & n0.br) | (g1 & n1.br);
    end

endmodule

// File: rtl/issue_slot_checker.sv
module issue_slot_checker
    import issue_slot_pkg::*;
#(
    parameter int MEM_HOLD = 3,
    parameter int BR_HOLD  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s0_valid,
    input  logic [CLS_W-1:0] s0_class,
    input  logic             s1_valid,
    input  logic [CLS_W-1:0] s1_class,
    output logic             s0_grant,
    output logic             s1_grant
);

    logic             valid_a [NSLOT];
    logic [CLS_W-1:0] cls_a   [NSLOT];
    slot_need_t       need_a  [NSLOT];
    logic mem_busy, br_busy, mem_claim, br_claim;

    assign valid_a[0] = s0_valid;
    assign valid_a[1] = s1_valid;
    assign cls_a[0]   = s0_class;
    assign cls_a[1]   = s1_class;

    for (genvar s = 0; s < NSLOT; s++) begin : g_dec
        slot_decode u_dec (
            .valid (valid_a[s]),
            .cls   (cls_a[s]),
            .need  (need_a[s])
        );
    end

    pair_arbiter u_arb (
        .n0        (need_a[0]),
        .n1        (need_a[1]),
        .v0        (s0_valid),
        .v1        (s1_valid),
        .mem_busy  (mem_busy),
        .br_busy   (br_busy),
        .g0        (s0_grant),
        .g1        (s1_grant),
        .mem_claim (mem_claim),
        .br_claim  (br_claim)
    );

    unit_hold #(.HOLD(MEM_HOLD)) u_mem_hold (
        .clk (clk), .rst (rst), .claim (mem_claim), .busy (mem_busy)
    );

    unit_hold #(.HOLD(BR_HOLD)) u_br_hold (
        .clk (clk), .rst (rst), .claim (br_claim), .busy (br_busy)
    );

    p_in_order_r3: assert property (@(posedge clk) disable iff (rst)
        s1_grant |-> s0_grant);

    p_multi_alone_r4: assert property (@(posedge clk) disable iff (rst)
        (s0_valid && s1_valid &&
         (s0_class == C_MULTI || s1_class == C_MULTI)) |-> !s1_grant);

    p_mem_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_busy && need_a[0].mem) |-> !s0_grant);

    p_branch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        br_claim |=> br_busy);

    p_invalid_r10: assert property (@(posedge clk) disable iff (rst)
        !s0_valid |-> (!s0_grant && !s1_grant));

endmodule

// File: tb/issue_slot_checker_tb.sv
module issue_slot_checker_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       s0_valid, s1_valid;
    logic [3:0] s0_class, s1_class;
    logic       s0_grant, s1_grant;

    int checks = 0;
    int errors = 0;
    int m_mem  = 0;
    int m_br   = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    issue_slot_checker u_dut (
        .clk (clk), .rst (rst),
        .s0_valid (s0_valid), .s0_class (s0_class),
        .s1_valid (s1_valid), .s1_class (s1_class),
        .s0_grant (s0_grant), .s1_grant (s1_grant)
    );

    // bus mask: bit0 = bus 0, bit1 = bus 1; 0 means either bus (load)
    function automatic int busmask(input logic [3:0] c);
        case (c)
            0: return 3;
            1: return 0;
            4, 9, 10, 11, 12: return 1;
            default: return 2;
        endcase
    endfunction

    // unit: 0 none, 1 memory, 2 branch, 3 integer, 4 FP
    function automatic int unit_of(input logic [3:0] c);
        if (c >= 1 && c <= 5) return 1;
        if (c >= 6 && c <= 9) return 2;
        if (c >= 10 && c <= 12) return 3;
        if (c == 13) return 4;
        return 0;
    endfunction

    function automatic bit held(input logic [3:0] c);
        return (unit_of(c) == 1 && m_mem > 0) || (unit_of(c) == 2 && m_br > 0);
    endfunction

    function automatic bit exp_g0(input bit v0, input logic [3:0] c0);
        return v0 && !held(c0);
    endfunction

    function automatic bit exp_g1(input bit v0, input logic [3:0] c0,
                                  input bit v1, input logic [3:0] c1);
        int b0, b1, u0, u1;
        b0 = busmask(c0); b1 = busmask(c1);
        u0 = unit_of(c0); u1 = unit_of(c1);
        if (!exp_g0(v0, c0) || !v1 || held(c1)) return 0;
        if (b0 == 3 || b1 == 3) return 0;
        if (b0 != 0 && b1 != 0 && (b0 & b1) != 0) return 0;
        if (u0 != 0 && u0 == u1) return 0;
        return 1;
    endfunction

    task automatic chk(input string tag, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic step(input bit v0, input logic [3:0] c0,
                        input bit v1, input logic [3:0] c1, input string tag);
        bit e0, e1;
        @(negedge clk);
        s0_valid = v0; s0_class = c0; s1_valid = v1; s1_class = c1;
        #1;
        e0 = exp_g0(v0, c0);
        e1 = exp_g1(v0, c0, v1, c1);
        chk({tag, " slot0"}, s0_grant, e0);
        chk({tag, " slot1"}, s1_grant, e1);
        @(posedge clk);
        if (m_mem > 0) m_mem--;
        else if ((e0 && c0 == 5) || (e1 && c1 == 5)) m_mem = 3;
        if (m_br > 0) m_br--;
        else if ((e0 && unit_of(c0) == 2) || (e1 && unit_of(c1) == 2)) m_br = 1;
    endtask

    task automatic expect_now(input string tag, input bit g0, input bit g1);
        #1;
        chk({tag, " slot0"}, s0_grant, g0);
        chk({tag, " slot1"}, s1_grant, g1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        rst = 1'b1;
        s0_valid = 0; s1_valid = 0; s0_class = 0; s1_class = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mem = 0; m_br = 0;

        // R1: units free straight after reset
        step(1, 4'd5, 0, 4'd0, "R1 barrier after reset");
        // R8: memory held for 3 cycles after barrier, free on the 4th
        step(1, 4'd1, 1, 4'd10, "R8 hold cycle 1");
        step(1, 4'd2, 0, 4'd0, "R8 hold cycle 2");
        step(1, 4'd10, 1, 4'd4, "R8 hold cycle 3");
        @(negedge clk);
        s0_valid = 1; s0_class = 4'd1; s1_valid = 1; s1_class = 4'd13;
        expect_now("R8 released", 1, 1);
        @(posedge clk);
        // R9: branch holds one extra cycle, expiry meets a new branch
        step(1, 4'd6, 1, 4'd10, "R9 branch issue");
        step(1, 4'd9, 0, 4'd0, "R9 held");
        step(1, 4'd10, 1, 4'd7, "R9 released in slot 1");
        step(1, 4'd13, 1, 4'd8, "R9 held in slot 1");
        step(1, 4'd14, 0, 4'd0, "R9 idle");
        // R6: load pairs on either side
        @(negedge clk);
        s0_valid = 1; s0_class = 4'd10; s1_valid = 1; s1_class = 4'd1;
        expect_now("R6 alu+load", 1, 1);
        s0_class = 4'd1; s1_class = 4'd13;
        expect_now("R6 load+fpop", 1, 1);
        s0_class = 4'd1; s1_class = 4'd0;
        expect_now("R4 load+multi", 1, 0);
        // R5: same fixed bus
        s0_class = 4'd10; s1_class = 4'd4;
        expect_now("R5 bus0 clash", 1, 0);
        s0_class = 4'd14; s1_class = 4'd13;
        expect_now("R5 bus1 clash", 1, 0);
        // R7: same unit
        s0_class = 4'd1; s1_class = 4'd2;
        expect_now("R7 memory clash", 1, 0);
        s0_class = 4'd13; s1_class = 4'd12;
        expect_now("R2 fpop+compare", 1, 1);
        // R4: multi in slot 0
        s0_class = 4'd0; s1_class = 4'd14;
        expect_now("R4 multi+misc", 1, 0);
        // R10: invalid slot 0 and no reservation
        s0_valid = 0; s0_class = 4'd5; s1_class = 4'd10;
        expect_now("R10 invalid slot0", 0, 0);
        @(posedge clk);
        @(negedge clk);
        s0_valid = 1; s0_class = 4'd1; s1_valid = 0;
        expect_now("R10 no reservation", 1, 0);
        @(posedge clk);
        m_mem = 0; m_br = 0;
        // R3: held slot 0 stops slot 1
        step(1, 4'd5, 0, 4'd0, "R3 setup");
        step(1, 4'd1, 1, 4'd13, "R3 in order");

        // random mix, model-checked
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] a, b;
            a = 4'($urandom_range(0, 15));
            b = 4'($urandom_range(0, 15));
            step(($urandom_range(0, 7) != 0), a, ($urandom_range(0, 3) != 0), b,
                 "R2/R5/R7 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule